// File: doc/BRIEF.md
# Banked GPIO Pin Register Block

This block holds the configuration and output state of 24 general-purpose pins, organised as three banks of eight. A host reaches it over a simple byte-wide register bus with separate write and read strobes. Each pin has a direction bit, a drive-type bit and a pull bit. Its output level is changed only by writing ones into a set register or into a clear register. From these bits the block derives, for every pin, the control lines toward a pad model: output enable, output value, open-drain select, pull-up, pull-down and analog (all-off) mode.

The type and pull bits are read one way for an output pin and another way for an input pin. The lowest sixteen pins are always usable. The upper bank is split into two four-pin groups, and each group has its own enable input. A disabled pin reads as zero, ignores writes and is held as an input with every pad control low. A readable state register returns the synchronised pad level for input pins and the output latch for output pins.

Top module: `gpx_pin_bank`

## Requirements
- R1: After a synchronous active-low reset, every stored bit is 0. All pins are inputs, pad_oe, pad_od, pad_pu, pad_pd and pad_out are 0, and bus_rdata is 0x00. Available pins show pad_ana = 1 because type 0 with pull 0 means analog.
- R2: Pin n maps to bit n%8 of the register at base + n/8. Direction (0 = input, 1 = output) is at 0x60–0x62, type at 0x64–0x66 and pull at 0x68–0x6A. All three are read/write. A read strobe in one cycle puts the addressed value on bus_rdata after that clock edge, and bus_rdata holds it until the next read.
- R3: Writing a byte to 0x6C–0x6E sets the output latch of every pin whose bit is 1. Bits written as 0 leave their latch unchanged. pad_out shows the latch of every available pin whatever its direction.
- R4: Writing a byte to 0x70–0x72 clears the output latch of every pin whose bit is 1. Bits written as 0 leave their latch unchanged.
- R5: An output pin has pad_oe = 1 and pad_pd = 0. Type 0 selects push-pull (pad_od = 0, no pull). Type 1 selects open-drain (pad_od = 1), and pull = 1 then enables pad_pu.
- R6: An input pin has pad_oe = 0. With type 1, pull = 1 gives pad_pu and pull = 0 gives pad_pd. With type 0, pull = 0 gives pad_ana and pull = 1 leaves the pin floating with all controls low. pad_pu and pad_pd are never both high.
- R7: The state registers 0x10–0x12 are read-only. For an output pin they return the latch. For an input pin they return pad_in after two synchronising flops, so a read captured at the first or second clock edge after a pad change still returns the old level.
- R8: Pins 16–19 are available only while grp_lo_en is 1, and pins 20–23 only while grp_hi_en is 1. An unavailable pin reads 0 in every register, ignores writes, and has every pad control output at 0.
- R9: Any other address, including the set and clear addresses and the gaps 0x63, 0x67, 0x6B, reads 0x00. A write to an unmapped address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Registered read data |
| grp_lo_en | input | 1 | Makes pins 16–19 available |
| grp_hi_en | input | 1 | Makes pins 20–23 available |
| pad_in | input | 24 | Pad levels seen from outside, asynchronous |
| pad_oe | output | 24 | Output enable per pin |
| pad_out | output | 24 | Output value per pin (latch) |
| pad_od | output | 24 | Open-drain select per pin |
| pad_pu | output | 24 | Pull-up enable per pin |
| pad_pd | output | 24 | Pull-down enable per pin |
| pad_ana | output | 24 | Analog mode (no drive, no pull) per pin |

## Verification
The pad decoding is driven with type/pull patterns that cover all four combinations inside a single byte, once for output pins and once for input pins. This separates push-pull from open-drain, and pull-up from pull-down, floating and analog, bit by bit. Set and clear writes use overlapping and disjoint masks, so that a write which disturbs the zero bits stands out. State reads mix driven and sampled pins in one byte, and reads repeated on consecutive cycles after a pad change show the exact synchroniser depth. The gated groups are exercised with writes issued before and after each enable, which shows that the writes were dropped rather than merely hidden.

// File: rtl/gpx_pkg.sv
// Shared address map and sizes for the banked GPIO pin block.
// Assumes a byte-wide register bus and at most 256 register addresses.
package gpx_pkg;
    localparam int GPX_ADDR_W     = 8;
    localparam int GPX_STATE_BASE = 'h10;
    localparam int GPX_DIR_BASE   = 'h60;
    localparam int GPX_TYPE_BASE  = 'h64;
    localparam int GPX_PULL_BASE  = 'h68;
    localparam int GPX_SET_BASE   = 'h6C;
    localparam int GPX_CLR_BASE   = 'h70;
endpackage

// File: rtl/gpx_sync.sv
// Two-flop synchroniser for the asynchronous pad inputs.
// Assumes each bit is independent; no bus coherency is promised.
module gpx_sync #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Two register stages, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpx_bank_regs.sv
// Configuration and output-latch registers for one bank of pins.
// Assumes at most one write strobe per cycle. Bits of unavailable pins are
// masked out of every write, so they keep their stored value.
module gpx_bank_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] avail,
    input  logic [W-1:0] wdata,
    input  logic         wr_dir,
    input  logic         wr_type,
    input  logic         wr_pull,
    input  logic         wr_set,
    input  logic         wr_clr,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] type_q,
    output logic [W-1:0] pull_q,
    output logic [W-1:0] out_q
);
    logic [W-1:0] wmask;

    // Only available pins may be written.
    always_comb wmask = wdata & avail;

    // Configuration registers: plain read/write on available bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            type_q <= '0;
            pull_q <= '0;
        end else begin
            if (wr_dir)  dir_q  <= (dir_q  & ~avail) | wmask;
            if (wr_type) type_q <= (type_q & ~avail) | wmask;
            if (wr_pull) pull_q <= (pull_q & ~avail) | wmask;
        end
    end

    // Output latch: write-one-to-set and write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (wr_set) begin
            out_q <= out_q | wmask;
        end else if (wr_clr) begin
            out_q <= out_q & ~wmask;
        end
    end
endmodule

// File: rtl/gpx_pad_ctrl.sv
// Decodes direction, type and pull bits of one bank into pad controls.
// Output pins: type selects push-pull or open-drain, pull enables pull-up.
// Input pins: type 1 selects a resistor (pull picks up or down), type 0
// with pull 0 is analog. Unavailable pins get all controls low.
module gpx_pad_ctrl #(
    parameter int W = 8
) (
    input  logic [W-1:0] avail,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] typ,
    input  logic [W-1:0] pull,
    input  logic [W-1:0] out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_od,
    output logic [W-1:0] pad_pu,
    output logic [W-1:0] pad_pd,
    output logic [W-1:0] pad_ana
);
    logic [W-1:0] is_out;
    logic [W-1:0] is_in;

    // Per-pin mode split, qualified by availability.
    always_comb begin
        is_out  = dir & avail;
        is_in   = ~dir & avail;
        pad_oe  = is_out;
        pad_out = out & avail;
        pad_od  = is_out & typ;
        pad_pu  = avail & typ & pull;
        pad_pd  = is_in & typ & ~pull;
        pad_ana = is_in & ~typ & ~pull;
    end
endmodule

// File: rtl/gpx_pin_bank.sv
// Top of the banked GPIO pin block: bus decode, per-bank registers, pad
// decode, input synchroniser and registered read mux.
// Assumes single-cycle bus strobes. The first ALWAYS_PINS pins are always
// available; the rest form two groups gated by grp_lo_en and grp_hi_en.
module gpx_pin_bank
    import gpx_pkg::*;
#(
    parameter int BANK_W      = 8,
    parameter int NUM_BANKS   = 3,
    parameter int ALWAYS_PINS = 16,
    localparam int PIN_W      = BANK_W * NUM_BANKS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        bus_addr,
    input  logic [BANK_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [BANK_W-1:0] bus_rdata,
    input  logic              grp_lo_en,
    input  logic              grp_hi_en,
    input  logic [PIN_W-1:0]  pad_in,
    output logic [PIN_W-1:0]  pad_oe,
    output logic [PIN_W-1:0]  pad_out,
    output logic [PIN_W-1:0]  pad_od,
    output logic [PIN_W-1:0]  pad_pu,
    output logic [PIN_W-1:0]  pad_pd,
    output logic [PIN_W-1:0]  pad_ana
);
    localparam int GRP_W = (PIN_W - ALWAYS_PINS) / 2;

    logic [PIN_W-1:0]  avail;
    logic [PIN_W-1:0]  pin_sync;
    logic [PIN_W-1:0]  dir_q;
    logic [PIN_W-1:0]  type_q;
    logic [PIN_W-1:0]  pull_q;
    logic [PIN_W-1:0]  out_q;
    logic [BANK_W-1:0] rd_mux;

    // Availability per pin from the two group enables.
    for (genvar p = 0; p < PIN_W; p++) begin : g_avail
        if (p < ALWAYS_PINS) begin : g_fixed
            assign avail[p] = 1'b1;
        end else if (p < ALWAYS_PINS + GRP_W) begin : g_lo
            assign avail[p] = grp_lo_en;
        end else begin : g_hi
            assign avail[p] = grp_hi_en;
        end
    end

    gpx_sync #(.W(PIN_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pin_sync)
    );

    // One register set and one pad decoder per bank.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int LO = b * BANK_W;
        logic wr_dir, wr_type, wr_pull, wr_set, wr_clr;

        assign wr_dir  = bus_wr && (bus_addr == 8'(GPX_DIR_BASE  + b));
        assign wr_type = bus_wr && (bus_addr == 8'(GPX_TYPE_BASE + b));
        assign wr_pull = bus_wr && (bus_addr == 8'(GPX_PULL_BASE + b));
        assign wr_set  = bus_wr && (bus_addr == 8'(GPX_SET_BASE  + b));
        assign wr_clr  = bus_wr && (bus_addr == 8'(GPX_CLR_BASE  + b));

        gpx_bank_regs #(.W(BANK_W)) u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .avail   (avail[LO +: BANK_W]),
            .wdata   (bus_wdata),
            .wr_dir  (wr_dir),
            .wr_type (wr_type),
            .wr_pull (wr_pull),
            .wr_set  (wr_set),
            .wr_clr  (wr_clr),
            .dir_q   (dir_q[LO +: BANK_W]),
            .type_q  (type_q[LO +: BANK_W]),
            .pull_q  (pull_q[LO +: BANK_W]),
            .out_q   (out_q[LO +: BANK_W])
        );

        gpx_pad_ctrl #(.W(BANK_W)) u_pad (
            .avail   (avail[LO +: BANK_W]),
            .dir     (dir_q[LO +: BANK_W]),
            .typ     (type_q[LO +: BANK_W]),
            .pull    (pull_q[LO +: BANK_W]),
            .out     (out_q[LO +: BANK_W]),
            .pad_oe  (pad_oe[LO +: BANK_W]),
            .pad_out (pad_out[LO +: BANK_W]),
            .pad_od  (pad_od[LO +: BANK_W]),
            .pad_pu  (pad_pu[LO +: BANK_W]),
            .pad_pd  (pad_pd[LO +: BANK_W]),
            .pad_ana (pad_ana[LO +: BANK_W])
        );
    end

    // Read multiplexer; unmatched addresses give zero.
    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_addr == 8'(GPX_STATE_BASE + b))
                rd_mux = avail[b*BANK_W +: BANK_W] &
                         ((dir_q[b*BANK_W +: BANK_W] & out_q[b*BANK_W +: BANK_W]) |
                          (~dir_q[b*BANK_W +: BANK_W] & pin_sync[b*BANK_W +: BANK_W]));
            if (bus_addr == 8'(GPX_DIR_BASE + b))
                rd_mux = avail[b*BANK_W +: BANK_W] & dir_q[b*BANK_W +: BANK_W];
            if (bus_addr == 8'(GPX_TYPE_BASE + b))
                rd_mux = avail[b*BANK_W +: BANK_W] & type_q[b*BANK_W +: BANK_W];
            if (bus_addr == 8'(GPX_PULL_BASE + b))
                rd_mux = avail[b*BANK_W +: BANK_W] & pull_q[b*BANK_W +: BANK_W];
        end
    end

    // Registered read data, updated on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/gpx_pin_bank_chk.sv
// Property checker for gpx_pin_bank, attached by bind. Reads ports only.
module gpx_pin_bank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  bus_addr,
    input logic [7:0]  bus_wdata,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [7:0]  bus_rdata,
    input logic        grp_lo_en,
    input logic        grp_hi_en,
    input logic [23:0] pad_oe,
    input logic [23:0] pad_out,
    input logic [23:0] pad_od,
    input logic [23:0] pad_pu,
    input logic [23:0] pad_pd,
    input logic [23:0] pad_ana
);
    // R8
    hi_group_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_hi_en |-> ((pad_oe[23:20] | pad_out[23:20] | pad_od[23:20] |
                         pad_pu[23:20] | pad_pd[23:20] | pad_ana[23:20]) == 4'h0));

    // R8
    lo_group_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_lo_en |-> ((pad_oe[19:16] | pad_out[19:16] | pad_od[19:16] |
                         pad_pu[19:16] | pad_pd[19:16] | pad_ana[19:16]) == 4'h0));

    // R6
    pull_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_pd) == 24'h0);

    // R6
    analog_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_ana & (pad_oe | pad_pu | pad_pd | pad_od)) == 24'h0);

    // R3
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h6C) |=>
        ((pad_out[7:0] & $past(bus_wdata)) == $past(bus_wdata)));

    // R4
    clear_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h70) |=>
        ((pad_out[7:0] & $past(bus_wdata)) == 8'h00));

    // R9
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 8'h00) |=> (bus_rdata == 8'h00));
endmodule

bind gpx_pin_bank gpx_pin_bank_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .grp_lo_en (grp_lo_en),
    .grp_hi_en (grp_hi_en),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .pad_od    (pad_od),
    .pad_pu    (pad_pu),
    .pad_pd    (pad_pd),
    .pad_ana   (pad_ana)
);

// File: tb/gpx_pin_bank_bench.sv
// Directed bench for gpx_pin_bank: one task per scenario, each checking itself.
module gpx_pin_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        grp_lo_en = 1'b0;
    logic        grp_hi_en = 1'b0;
    logic [23:0] pad_in = '0;
    logic [23:0] pad_oe, pad_out, pad_od, pad_pu, pad_pd, pad_ana;

    int n_chk  = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    gpx_pin_bank u_gpx_pin_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .grp_lo_en (grp_lo_en),
        .grp_hi_en (grp_hi_en),
        .pad_in    (pad_in),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out),
        .pad_od    (pad_od),
        .pad_pu    (pad_pu),
        .pad_pd    (pad_pd),
        .pad_ana   (pad_ana)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        chk("R1 pad_oe",  pad_oe,  24'h0);
        chk("R1 pad_out", pad_out, 24'h0);
        chk("R1 pad_pu|pd|od", pad_pu | pad_pd | pad_od, 24'h0);
        chk("R1 pad_ana", pad_ana, 24'h00FFFF);
        chk("R1 rdata",   bus_rdata, 8'h00);
    endtask

    task automatic t_gating();
        logic [7:0] v;
        wr(8'h62, 8'hFF);
        rd(8'h62, v);  chk("R8 write ignored while disabled", v, 8'h00);
        chk("R8 upper pads quiet", pad_oe[23:16], 8'h00);
        grp_lo_en = 1'b1;
        @(negedge clk);
        rd(8'h62, v);  chk("R8 earlier write was dropped", v, 8'h00);
        wr(8'h62, 8'hFF);
        rd(8'h62, v);  chk("R8 low group only", v, 8'h0F);
        chk("R8 pad_oe low group", pad_oe[23:16], 8'h0F);
        pad_in[23:20] = 4'hF;
        grp_hi_en = 1'b1;
        @(negedge clk);
        rd(8'h62, v);  chk("R8 high group write was dropped", v, 8'h0F);
        grp_hi_en = 1'b0;
        repeat (3) @(negedge clk);
        rd(8'h12, v);  chk("R8 disabled pin reads 0", v, 8'h00);
        wr(8'h62, 8'h00);
        pad_in[23:20] = 4'h0;
        grp_hi_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        wr(8'h60, 8'hC3);
        wr(8'h65, 8'h3C);
        wr(8'h6A, 8'h96);
        rd(8'h60, v);  chk("R2 dir bank0 readback",  v, 8'hC3);
        rd(8'h65, v);  chk("R2 type bank1 readback", v, 8'h3C);
        rd(8'h6A, v);  chk("R2 pull bank2 readback", v, 8'h96);
        chk("R2 pin 22 pull-up at bank2 bit6", pad_pu[22], 1'b0);
        rd(8'h64, v);  chk("R2 type bank0 untouched", v, 8'h00);
        wr(8'h60, 8'h00); wr(8'h65, 8'h00); wr(8'h6A, 8'h00);
    endtask

    task automatic t_set_clear();
        wr(8'h6C, 8'h0F); chk("R3 set low nibble",       pad_out[7:0], 8'h0F);
        wr(8'h6C, 8'h30); chk("R3 zero bits unchanged",  pad_out[7:0], 8'h3F);
        wr(8'h70, 8'h05); chk("R4 clear selected bits",  pad_out[7:0], 8'h3A);
        wr(8'h70, 8'h00); chk("R4 zero clear no effect", pad_out[7:0], 8'h3A);
        wr(8'h6D, 8'h80); chk("R3 set bank1 bit7 (pin 15)", pad_out, 24'h00803A);
    endtask

    task automatic t_out_modes();
        wr(8'h60, 8'hFF);
        wr(8'h64, 8'hF0);
        wr(8'h68, 8'hCC);
        chk("R5 oe",  pad_oe[7:0], 8'hFF);
        chk("R5 od",  pad_od[7:0], 8'hF0);
        chk("R5 pu only on open-drain", pad_pu[7:0], 8'hC0);
        chk("R5 pd|ana", pad_pd[7:0] | pad_ana[7:0], 8'h00);
    endtask

    task automatic t_in_modes();
        wr(8'h65, 8'h0F);
        wr(8'h69, 8'h35);
        chk("R6 oe",  pad_oe[15:8], 8'h00);
        chk("R6 pu",  pad_pu[15:8], 8'h05);
        chk("R6 pd",  pad_pd[15:8], 8'h0A);
        chk("R6 ana", pad_ana[15:8], 8'hC0);
        chk("R6 floating pins idle", pad_od[15:8], 8'h00);
    endtask

    task automatic t_state();
        logic [7:0] v;
        wr(8'h60, 8'h0F);
        pad_in[7:0] = 8'hF5;
        repeat (3) @(negedge clk);
        rd(8'h10, v);  chk("R7 mixed outputs latch, inputs pad", v, 8'hFA);
        pad_in[15:8] = 8'h5A;
        rd(8'h11, v);  chk("R7 first edge still old",  v, 8'h00);
        rd(8'h11, v);  chk("R7 second edge still old", v, 8'h00);
        rd(8'h11, v);  chk("R7 third edge new",        v, 8'h5A);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        wr(8'h63, 8'hFF);
        rd(8'h63, v);  chk("R9 gap reads 0", v, 8'h00);
        rd(8'h60, v);  chk("R9 gap write no effect", v, 8'h0F);
        rd(8'h6C, v);  chk("R9 set address reads 0", v, 8'h00);
        rd(8'h00, v);  chk("R9 addr 0 reads 0", v, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_gating();
        t_regs();
        t_set_clear();
        t_out_modes();
        t_in_modes();
        t_state();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule